// File: doc/BRIEF.md
# Two-Level Interrupt Priority Vector Generator

This block watches nine peripheral interrupt request lines and, on every clock, chooses a single winning request. Each source has a fixed interrupt level and a fixed rank within that level. The request with the highest level wins. When two active requests share a level, the higher rank decides. From the winner, the block produces its level, its vector number and the byte address of its vector table entry. The address is built from a base register held inside the block.

A processor interrupt mask input is compared against the winner's level. The pending output rises only when the winner is allowed to interrupt. Level 7 cannot be masked. The winner outputs and the pending flag are registered, so they follow the request inputs with one cycle of latency. The base register can be written, and only the upper twelve bits of it are kept. This forces the table onto a 1 MB boundary.

Top module: `intc_vecgen`

## Requirements
- R1: Request bit i (0 to 8) maps to vector number 64+i. Bit 0 is the external pin source, bit 1 is low-voltage detect, bit 2 is clock lock, and bits 3 to 8 are timer channels 0 to 5. A lone active request reports its own vector.
- R2: Bits 0 to 2 are at level 7 and bits 3 to 8 are at level 5. Any active level-7 request beats every level-5 request.
- R3: Within level 7 the order is bit 0 (middle rank) above bit 1 (rank 3) above bit 2 (rank 2). Within level 5 the order is bit 3 above bit 4, and so on down to bit 8 (ranks 6 down to 1).
- R4: The vector address output equals the stored base plus 4 times the winning vector number.
- R5: The base register stores only write-data bits 31:20. Bits 19:0 always read as zero. Its reset value is 0x0000_0000.
- R6: A level-7 winner asserts pending whatever the 3-bit mask value is.
- R7: A winner below level 7 asserts pending only when its level is strictly greater than the mask.
- R8: With no request active, the block reports level 0 and vector 0, pending is low, and the address equals the base.
- R9: Level, vector, address and pending change on the first rising edge after the request and mask inputs change, and not before.
- R10: While reset is held, the level, vector, address, pending and base outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 9 | Interrupt request lines, one per source |
| int_mask | input | 3 | Processor interrupt mask level |
| vbr_wr_en | input | 1 | Base register write strobe |
| vbr_wr_data | input | 32 | Base register write data |
| vbr_q | output | 32 | Stored base register value |
| win_level | output | 3 | Winning interrupt level, 0 when idle |
| win_vector | output | 8 | Winning vector number, 0 when idle |
| vec_addr | output | 32 | Vector table entry address of the winner |
| int_pending | output | 1 | Winner may interrupt the processor |

## Verification
Directed patterns come first. Single-source requests confirm the vector map. Pairs that span the two levels separate level priority from rank. Pairs inside one level expose any ordering error among the sub-ranks. Mask sweeps against a level-5 and a level-7 winner separate the strict comparison from a greater-or-equal one, and show that level 7 is unmaskable. Random request vectors that are dense or sparse are then checked against a bench priority model, under several base values that include ones with low write-data bits set.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC   = 9;
    localparam int LVL_W     = 3;
    localparam int SUB_W     = 4;
    localparam int VEC_W     = 8;
    localparam int ADDR_W    = 32;
    localparam int BASE_LSB  = 20;
    localparam int VEC_BASE  = 64;
    localparam logic [SUB_W-1:0] SUB_MID = 4'd7;  // between rank 4 (8) and rank 3 (6)

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        lvl_t             level;
        logic [SUB_W-1:0] sub;
        vec_t             vector;
    } src_attr_t;

    typedef struct packed {
        logic valid;
        lvl_t level;
        vec_t vector;
    } win_t;

    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W)'(1) << BASE_LSB) + 1;

    // Ranks are doubled so the middle slot fits between two integer ranks.
    function automatic src_attr_t src_attr(input int idx);
        src_attr_t a;
        a.vector = VEC_W'(VEC_BASE + idx);
        case (idx)
            0:       begin a.level = 3'd7; a.sub = SUB_MID; end
            1:       begin a.level = 3'd7; a.sub = 4'd6;    end
            2:       begin a.level = 3'd7; a.sub = 4'd4;    end
            default: begin a.level = 3'd5; a.sub = SUB_W'(2 * (9 - idx)); end
        endcase
        return a;
    endfunction

    function automatic logic may_interrupt(input lvl_t lvl, input lvl_t mask);
        return (lvl == 3'd7) || (lvl > mask);
    endfunction

endpackage

// File: rtl/intc_src_map.sv
module intc_src_map
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    output src_attr_t attr [NSRC]
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign attr[g] = src_attr(g);
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0] req,
    input  src_attr_t       attr [NSRC],
    output logic [NSRC-1:0] grant,
    output win_t            win
);
    localparam int KEY_W = LVL_W + SUB_W;

    logic [KEY_W-1:0] key [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_key
        assign key[g] = req[g] ? {attr[g].level, attr[g].sub} : '0;
    end

    always_comb begin
        logic [KEY_W-1:0] best;
        best  = '0;
        grant = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (key[i] > best) begin
                best  = key[i];
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        win = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                win.valid  = 1'b1;
                win.level  = attr[i].level;
                win.vector = attr[i].vector;
            end
        end
    end

    always_comb begin
        assert ($onehot0(grant));                       // R3
        assert ((grant == '0) == (req == '0));          // R8
    end
endmodule

// File: rtl/intc_vbr_reg.sv
module intc_vbr_reg
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data & BASE_MASK;
    end

    AST_VBR_LOW_ZERO: assert property (@(posedge clk) q[BASE_LSB-1:0] == '0); // R5
endmodule

// File: rtl/intc_vecgen.sv
module intc_vecgen
    import intc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [8:0]  irq_req,
    input  logic [2:0]  int_mask,
    input  logic        vbr_wr_en,
    input  logic [31:0] vbr_wr_data,
    output logic [31:0] vbr_q,
    output logic [2:0]  win_level,
    output logic [7:0]  win_vector,
    output logic [31:0] vec_addr,
    output logic        int_pending
);
    src_attr_t        attr [NUM_SRC];
    logic [NUM_SRC-1:0] grant;
    win_t             win;

    intc_src_map #(.NSRC(NUM_SRC)) u_map (.attr(attr));

    intc_arbiter #(.NSRC(NUM_SRC)) u_arb (
        .req  (irq_req),
        .attr (attr),
        .grant(grant),
        .win  (win)
    );

    intc_vbr_reg u_vbr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (vbr_wr_en),
        .wr_data(vbr_wr_data),
        .q      (vbr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_level   <= '0;
            win_vector  <= '0;
            vec_addr    <= '0;
            int_pending <= 1'b0;
        end else begin
            win_level   <= win.level;
            win_vector  <= win.vector;
            vec_addr    <= vbr_q + {22'd0, win.vector, 2'b00};
            int_pending <= win.valid && may_interrupt(win.level, int_mask);
        end
    end

    AST_LVL7_PENDING: assert property (@(posedge clk) disable iff (rst)
        (win_level == 3'd7) |-> int_pending);                         // R6
    AST_PEND_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        int_pending |-> (win_level != 3'd0));                         // R7
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        (irq_req == '0) |=> (win_level == 3'd0 && win_vector == 8'd0 && !int_pending)); // R8
    AST_ADDR_WORD: assert property (@(posedge clk) vec_addr[1:0] == 2'b00); // R4
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (win_level != 3'd0) |-> (win_vector >= 8'd64 && win_vector <= 8'd72)); // R1
endmodule

// File: tb/intc_vecgen_bench.sv
module intc_vecgen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  irq_req;
    logic [2:0]  int_mask;
    logic        vbr_wr_en;
    logic [31:0] vbr_wr_data;
    logic [31:0] vbr_q;
    logic [2:0]  win_level;
    logic [7:0]  win_vector;
    logic [31:0] vec_addr;
    logic        int_pending;

    int checks = 0;
    int errors = 0;
    logic [31:0] base_exp = 32'd0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    intc_vecgen u_intc_vecgen (
        .clk(clk), .rst(rst), .irq_req(irq_req), .int_mask(int_mask),
        .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data), .vbr_q(vbr_q),
        .win_level(win_level), .win_vector(win_vector), .vec_addr(vec_addr),
        .int_pending(int_pending)
    );

    function automatic int lvl_of(input int i);
        return (i < 3) ? 7 : 5;
    endfunction

    // Doubled ranks: middle = 7, rank r = 2r.
    function automatic int rank_of(input int i);
        case (i)
            0: return 7;
            1: return 6;
            2: return 4;
            default: return 2 * (9 - i);
        endcase
    endfunction

    function automatic int winner(input logic [8:0] r);
        int best = -1;
        for (int i = 0; i < 9; i++)
            if (r[i] && (best < 0 || lvl_of(i) * 16 + rank_of(i) > lvl_of(best) * 16 + rank_of(best)))
                best = i;
        return best;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [8:0] r, input logic [2:0] m, input string tag);
        int w;
        int lv;
        int vc;
        logic pend;
        @(negedge clk);
        irq_req = r;
        int_mask = m;
        @(negedge clk);
        w  = winner(r);
        lv = (w < 0) ? 0 : lvl_of(w);
        vc = (w < 0) ? 0 : 64 + w;
        pend = (lv == 7) || (lv != 0 && lv > int'(m));
        check({tag, " level"},   32'(win_level),  32'(lv));
        check({tag, " vector"},  32'(win_vector), 32'(vc));
        check({tag, " address R4"}, vec_addr,     base_exp + 32'(4 * vc));
        check({tag, " pending"}, 32'(int_pending), 32'(pend));
    endtask

    task automatic write_base(input logic [31:0] d);
        @(negedge clk);
        vbr_wr_en = 1'b1;
        vbr_wr_data = d;
        @(negedge clk);
        vbr_wr_en = 1'b0;
        base_exp = d & 32'hFFF0_0000;
        check("R5 base readback", vbr_q, base_exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        irq_req = '0;
        int_mask = '0;
        vbr_wr_en = 1'b0;
        vbr_wr_data = '0;
        repeat (3) @(negedge clk);
        // R10: reset state, even with requests active
        irq_req = 9'h1FF;
        @(negedge clk);
        check("R10 level",   32'(win_level),  0);
        check("R10 vector",  32'(win_vector), 0);
        check("R10 address", vec_addr,        0);
        check("R10 pending", 32'(int_pending), 0);
        check("R10 base",    vbr_q,           0);
        irq_req = '0;
        rst = 1'b0;

        apply(9'h000, 3'd0, "R8 idle");
        for (int i = 0; i < 9; i++) apply(9'(1 << i), 3'd0, "R1 single");
        apply(9'b100000100, 3'd0, "R2 lvl7 vs ch5");
        apply(9'b000001100, 3'd6, "R2 lock vs ch0");
        apply(9'b000000111, 3'd0, "R3 lvl7 all");
        apply(9'b000000110, 3'd0, "R3 lvd vs lock");
        apply(9'b111111000, 3'd0, "R3 timers all");
        apply(9'b110000000, 3'd0, "R3 ch4 vs ch5");
        apply(9'b000110000, 3'd0, "R3 ch1 vs ch2");
        for (int m = 0; m < 8; m++) apply(9'b000000100, 3'(m), "R6 lvl7 mask");
        for (int m = 0; m < 8; m++) apply(9'b001000000, 3'(m), "R7 lvl5 mask");

        write_base(32'h123F_FFFF);
        apply(9'b000001000, 3'd0, "R4 base ch0");
        apply(9'h000, 3'd0, "R8 idle base");
        write_base(32'hFFFF_FFFF);
        apply(9'b000000001, 3'd7, "R4 base irq");

        // R9: nothing moves before the edge
        @(negedge clk);
        irq_req = 9'b100000000;
        int_mask = 3'd0;
        #1;
        check("R9 level held",  32'(win_level),  7);
        check("R9 vector held", 32'(win_vector), 64);
        @(negedge clk);
        check("R9 level new",  32'(win_level),  5);
        check("R9 vector new", 32'(win_vector), 72);

        begin
            int seed = 17;
            void'($urandom(seed));
        end
        for (int n = 0; n < 400; n++) begin
            logic [8:0] r;
            r = 9'($urandom);
            if (n % 3 == 0) r = r & 9'($urandom) & 9'($urandom);
            if (n % 100 == 50) write_base($urandom);
            apply(r, 3'($urandom), "R1 R2 R3 R7 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule